// File: doc/BRIEF.md
# Prioritised Transfer Request Queues with Occupancy Watermark

This block sits between the event capture logic of a DMA channel controller and its transfer engines. Each incoming request carries a channel number and names the queue it belongs to. It is held in that queue in arrival order. Every queue feeds its own transfer engine through a valid/ready pair. Only one queue head is released per cycle. The head released is chosen by a priority value per queue that software programs.

For debug and for sizing the queues, each queue keeps three things. The first is a peak-occupancy watermark. The second is a live flag that is high while occupancy is above a programmable threshold. The third is a sticky error bit that records a request dropped because the queue was full. A small register port reads back priorities, thresholds, watermarks and status, and writes them. The queue count defaults to two and may be set up to four. Each queue holds sixteen entries by default.

Top module: `evq_sched`

## Requirements
- R1: Each queue holds up to DEPTH (default 16) entries. Its occupancy never exceeds DEPTH and changes by at most one per cycle. Entries leave a queue in the order they arrived.
- R2: A cycle with `req_valid_i` high appends `req_chan_i` to the queue whose index equals `req_queue_i`. The head entry of queue q is always driven on `disp_chan_o[q*CH_W +: CH_W]`.
- R3: `disp_valid_o[q]` is high only while queue q is non-empty and `disp_ready_i[q]` is high. The head is removed at the clock edge where `disp_valid_o[q]` is high.
- R4: At most one bit of `disp_valid_o` is high in a cycle. If at least one queue is non-empty with its ready high, exactly one bit is high.
- R5: Among the eligible queues, the one with the numerically lowest priority value is dispatched. On equal values, the lower queue index wins.
- R6: A request to a queue that already holds DEPTH entries is discarded, and it sets that queue's sticky overflow bit (`ovf_err_o[q]`, status bit 1). This holds even if the queue pops in the same cycle. Writing status with data bit 1 set clears the bit. If a set and a clear occur in the same cycle, the set wins.
- R7: The watermark of a queue takes the new occupancy at the edge where an enqueue without a simultaneous pop raises occupancy above the stored value. Any write to the watermark register clears it to 0, and a clear wins over a concurrent raise. Pops never lower it.
- R8: `thr_hit_o[q]` (status bit 0) is high exactly while the occupancy of queue q is strictly greater than its threshold.
- R9: After reset, all queues are empty, no dispatch is offered, and the flags and watermarks are 0. Queue q has priority q and threshold DEPTH.
- R10: The register address is {kind[1:0], queue}. Kind 0 is priority (read/write, low PRIO_W bits). Kind 1 is threshold (read/write, low CNT_W bits). Kind 2 is the watermark (read; any write clears it). Kind 3 is status: bit 0 is the threshold flag, bit 1 is overflow, and bits starting at 8 hold the occupancy. Reads are combinational, and a queue index of NUM_Q or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_chan_i | input | CH_W | Channel number of the request |
| req_queue_i | input | QSEL_W | Target queue index |
| disp_valid_o | output | NUM_Q | Per-queue dispatch valid, at most one high |
| disp_ready_i | input | NUM_Q | Per-queue engine ready |
| disp_chan_o | output | NUM_Q*CH_W | Head channel of each queue |
| thr_hit_o | output | NUM_Q | Occupancy above threshold, per queue |
| ovf_err_o | output | NUM_Q | Sticky overflow error, per queue |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | QSEL_W+2 | Register address {kind, queue} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |

## Verification
The hardest case to reach from the ports is a set of queues that all hold entries at once, with every ordering of priority values. That includes the ordering where all four values are equal. The bench gets there by holding every ready low while it loads one entry into each of four queues. It then raises all readies together and records the order in which the queues drain. It repeats this for all 256 priority assignments with two-bit priorities. The overflow boundary gets similar treatment: a queue is filled to exactly DEPTH before a seventeenth request is sent, and that request must disappear from the drained sequence.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    KIND_PRIO = 2'd0,
    KIND_THR  = 2'd1,
    KIND_WM   = 2'd2,
    KIND_STAT = 2'd3
  } reg_kind_e;

  localparam int STAT_THR_BIT = 0;
  localparam int STAT_OVF_BIT = 1;
  localparam int STAT_OCC_LSB = 8;
  localparam int REG_W        = 32;
endpackage

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      count_o <= count_o + 1'b1;
      else if (pop_i && !push_i) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign head_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/evq_stats.sv
module evq_stats #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             drop_i,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             wm_clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] wm_o,
  output logic             ovf_o,
  output logic             thr_hit_o
);
  logic [CNT_W-1:0] occ_up;
  assign occ_up = occ_i + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_o  <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wm_clr_i)                                   wm_o <= '0;
      else if (push_i && !pop_i && (occ_up > wm_o))   wm_o <= occ_up;
      if (drop_i)         ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  assign thr_hit_o = occ_i > thr_i;
endmodule

// File: rtl/evq_arb.sv
module evq_arb #(
  parameter int NUM_Q  = 2,
  parameter int PRIO_W = 3
) (
  input  logic [NUM_Q-1:0]             cand_i,
  input  logic [NUM_Q-1:0][PRIO_W-1:0] prio_i,
  output logic [NUM_Q-1:0]             grant_o
);
  logic              found;
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    best    = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (cand_i[q] && (!found || prio_i[q] < best)) begin
        found      = 1'b1;
        best       = prio_i[q];
        grant_o    = '0;
        grant_o[q] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evq_sched.sv
module evq_sched
  import evq_pkg::*;
#(
  parameter int NUM_Q  = 2,
  parameter int DEPTH  = 16,
  parameter int CH_W   = 6,
  parameter int PRIO_W = 3,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = QSEL_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [CH_W-1:0]       req_chan_i,
  input  logic [QSEL_W-1:0]     req_queue_i,
  output logic [NUM_Q-1:0]      disp_valid_o,
  input  logic [NUM_Q-1:0]      disp_ready_i,
  output logic [NUM_Q*CH_W-1:0] disp_chan_o,
  output logic [NUM_Q-1:0]      thr_hit_o,
  output logic [NUM_Q-1:0]      ovf_err_o,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o
);
  logic [NUM_Q-1:0][CNT_W-1:0]  occ;
  logic [NUM_Q-1:0][CNT_W-1:0]  wm;
  logic [NUM_Q-1:0][CNT_W-1:0]  thr_q;
  logic [NUM_Q-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_Q-1:0]             push, pop, drop, cand;

  reg_kind_e         acc_kind;
  logic [QSEL_W-1:0] acc_q;
  logic              unused_wdata;

  assign acc_kind     = reg_kind_e'(reg_addr_i[ADDR_W-1 -: 2]);
  assign acc_q        = reg_addr_i[QSEL_W-1:0];
  assign unused_wdata = ^reg_wdata_i;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic sel, full, hit_me;
    assign sel     = req_valid_i && (req_queue_i == QSEL_W'(q));
    assign full    = occ[q] == CNT_W'(DEPTH);
    assign push[q] = sel && !full;
    assign drop[q] = sel && full;
    assign cand[q] = (occ[q] != '0) && disp_ready_i[q];
    assign pop[q]  = disp_valid_o[q];
    assign hit_me  = reg_we_i && (acc_q == QSEL_W'(q));

    evq_fifo #(.DEPTH(DEPTH), .DW(CH_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[q]),
      .data_i  (req_chan_i),
      .pop_i   (pop[q]),
      .head_o  (disp_chan_o[q*CH_W +: CH_W]),
      .count_o (occ[q])
    );

    evq_stats #(.DEPTH(DEPTH)) u_stats (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push[q]),
      .pop_i     (pop[q]),
      .drop_i    (drop[q]),
      .occ_i     (occ[q]),
      .thr_i     (thr_q[q]),
      .wm_clr_i  (hit_me && acc_kind == KIND_WM),
      .ovf_clr_i (hit_me && acc_kind == KIND_STAT && reg_wdata_i[STAT_OVF_BIT]),
      .wm_o      (wm[q]),
      .ovf_o     (ovf_err_o[q]),
      .thr_hit_o (thr_hit_o[q])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q[q] <= PRIO_W'(q);
        thr_q[q]  <= CNT_W'(DEPTH);
      end else if (hit_me) begin
        if (acc_kind == KIND_PRIO) prio_q[q] <= reg_wdata_i[PRIO_W-1:0];
        if (acc_kind == KIND_THR)  thr_q[q]  <= reg_wdata_i[CNT_W-1:0];
      end
    end
  end

  evq_arb #(.NUM_Q(NUM_Q), .PRIO_W(PRIO_W)) u_arb (
    .cand_i  (cand),
    .prio_i  (prio_q),
    .grant_o (disp_valid_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (int'(acc_q) < NUM_Q) begin
      unique case (acc_kind)
        KIND_PRIO: reg_rdata_o[PRIO_W-1:0] = prio_q[acc_q];
        KIND_THR:  reg_rdata_o[CNT_W-1:0]  = thr_q[acc_q];
        KIND_WM:   reg_rdata_o[CNT_W-1:0]  = wm[acc_q];
        KIND_STAT: begin
          reg_rdata_o[STAT_THR_BIT]              = thr_hit_o[acc_q];
          reg_rdata_o[STAT_OVF_BIT]              = ovf_err_o[acc_q];
          reg_rdata_o[STAT_OCC_LSB +: CNT_W]     = occ[acc_q];
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/evq_sched_chk.sv
module evq_sched_chk #(
  parameter int NUM_Q  = 2,
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 3,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = QSEL_W + 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_Q-1:0]            disp_valid_o,
  input logic [NUM_Q-1:0]            disp_ready_i,
  input logic [NUM_Q-1:0]            ovf_err_o,
  input logic [NUM_Q-1:0][CNT_W-1:0] occ_i,
  input logic [NUM_Q-1:0][PRIO_W-1:0] prio_i,
  input logic                        reg_we_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic                        clr_bit_i
);
  logic [NUM_Q-1:0] elig;
  for (genvar q = 0; q < NUM_Q; q++) begin : g_e
    assign elig[q] = disp_ready_i[q] && (occ_i[q] != '0);
  end

  // R4
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_valid_o));
  // R4
  work_cons_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig) |-> (|disp_valid_o));

  for (genvar a = 0; a < NUM_Q; a++) begin : g_a
    // R3
    eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[a] |-> elig[a]);
    // R1
    bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i[a] <= CNT_W'(DEPTH));
    // R1
    step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (occ_i[a] == $past(occ_i[a]) || occ_i[a] == $past(occ_i[a]) + 1'b1
                || occ_i[a] == $past(occ_i[a]) - 1'b1));
    // R6
    sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_err_o[a] && !(reg_we_i && clr_bit_i &&
        reg_addr_i == {2'd3, QSEL_W'(a)})) |=> ovf_err_o[a]);
    for (genvar b = 0; b < NUM_Q; b++) begin : g_b
      if (a != b) begin : g_pair
        localparam bit A_LOWER = (a < b);
        // R5
        prio_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (disp_valid_o[a] && elig[b]) |->
            (prio_i[a] < prio_i[b] || (prio_i[a] == prio_i[b] && A_LOWER)));
      end
    end
  end
endmodule

bind evq_sched evq_sched_chk #(
  .NUM_Q(NUM_Q), .DEPTH(DEPTH), .PRIO_W(PRIO_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_o (disp_valid_o),
  .disp_ready_i (disp_ready_i),
  .ovf_err_o    (ovf_err_o),
  .occ_i        (occ),
  .prio_i       (prio_q),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .clr_bit_i    (reg_wdata_i[1])
);

// File: tb/evq_sched_bench.sv
module evq_sched_bench;
  localparam int NQ = 4, DP = 16, CW = 6, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CW-1:0] req_chan = '0;
  logic [1:0] req_q = '0;
  logic [NQ-1:0] valid, ready = '0, thr_hit, ovf;
  logic [NQ*CW-1:0] chan;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evq_sched #(.NUM_Q(NQ), .DEPTH(DP), .CH_W(CW), .PRIO_W(PW)) u_evq_sched (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_chan_i(req_chan),
    .req_queue_i(req_q), .disp_valid_o(valid), .disp_ready_i(ready),
    .disp_chan_o(chan), .thr_hit_o(thr_hit), .ovf_err_o(ovf),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] kind, input logic [1:0] q, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = {kind, q}; wdata = d;
    @(posedge clk); #1; we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] kind, input logic [1:0] q, output logic [31:0] d);
    addr = {kind, q}; #1; d = rdata;
  endtask

  task automatic enq(input logic [1:0] q, input logic [CW-1:0] c);
    @(negedge clk); req_valid = 1'b1; req_q = q; req_chan = c;
    @(posedge clk); #1; req_valid = 1'b0;
  endtask

  function automatic logic [CW-1:0] head(input int q);
    return chan[q*CW +: CW];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 reset state
    check("R9 valid", valid, 0);
    check("R9 flags", {thr_hit, ovf}, 0);
    for (int q = 0; q < NQ; q++) begin
      reg_rd(2'd0, 2'(q), d); check("R9 prio", d, q);
      reg_rd(2'd1, 2'(q), d); check("R9 thr", d, DP);
      @(posedge clk); #1;
      reg_rd(2'd2, 2'(q), d); check("R9 wm", d, 0);
      reg_rd(2'd3, 2'(q), d); check("R9 status", d, 0);
      @(posedge clk); #1;
    end

    // R2 R3 FIFO order on queue 1
    for (int k = 0; k < 3; k++) enq(2'd1, 6'(5 + k));
    reg_rd(2'd3, 2'd1, d); check("R10 occupancy", d, 32'(3 << 8));
    check("R3 held while not ready", valid, 0);
    ready = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      #1; check("R3 valid q1", valid, 4'b0010);
      check("R2 head order", head(1), 5 + k);
      @(posedge clk); #1;
    end
    check("R3 empty no valid", valid, 0);
    ready = '0;

    // R3 R5 ready masking
    enq(2'd0, 6'd1); enq(2'd3, 6'd3);
    ready = 4'b1000; #1;
    check("R3 skip not-ready q0", valid, 4'b1000);
    ready = 4'b1001; #1;
    check("R5 q0 wins", valid, 4'b0001);
    @(posedge clk); #1;
    check("R3 q3 after pop", valid, 4'b1000);
    check("R2 q3 head", head(3), 3);
    @(posedge clk); #1;
    check("R4 drained", valid, 0);
    ready = '0;

    // R6 R1 overflow boundary on queue 2
    for (int k = 0; k < DP; k++) enq(2'd2, 6'(k));
    check("R6 no ovf at full", ovf, 0);
    check("R8 no hit at thr=DEPTH", thr_hit, 0);
    reg_rd(2'd2, 2'd2, d); check("R7 wm full", d, DP);
    enq(2'd2, 6'd63);
    check("R6 ovf set", ovf, 4'b0100);
    reg_rd(2'd3, 2'd2, d); check("R6 occupancy held", d[12:8], DP);
    ready = 4'b0100;
    for (int k = 0; k < DP; k++) begin
      #1; check("R1 drain order", head(2), k);
      @(posedge clk); #1;
    end
    check("R1 dropped entry absent", valid, 0);
    ready = '0;
    reg_rd(2'd2, 2'd2, d); check("R7 wm kept after drain", d, DP);
    reg_wr(2'd2, 2'd2, 32'd0);
    reg_rd(2'd2, 2'd2, d); check("R7 wm cleared", d, 0);
    check("R6 ovf still sticky", ovf, 4'b0100);
    reg_wr(2'd3, 2'd2, 32'd2);
    check("R6 ovf cleared", ovf, 0);

    // R8 threshold
    reg_wr(2'd1, 2'd2, 32'd3);
    for (int k = 0; k < 3; k++) enq(2'd2, 6'(k));
    check("R8 at threshold", thr_hit, 0);
    enq(2'd2, 6'd9);
    check("R8 above threshold", thr_hit, 4'b0100);
    reg_rd(2'd3, 2'd2, d); check("R8 status bit", d[0], 1);
    reg_rd(2'd2, 2'd2, d); check("R7 wm after clear", d, 4);
    ready = 4'b0100;
    @(posedge clk); #1;
    check("R8 drop below", thr_hit, 0);
    repeat (3) @(posedge clk);
    #1; ready = '0;
    check("R1 q2 empty", valid, 0);

    // R7 simultaneous push and pop
    reg_wr(2'd2, 2'd1, 32'd0);
    enq(2'd1, 6'd20); enq(2'd1, 6'd21);
    ready = 4'b0010;
    enq(2'd1, 6'd22);
    ready = '0;
    reg_rd(2'd3, 2'd1, d); check("R7 occ same on push+pop", d[12:8], 2);
    reg_rd(2'd2, 2'd1, d); check("R7 wm not raised", d, 2);
    ready = 4'b0010;
    repeat (2) @(posedge clk);
    #1; ready = '0;

    // R5 R4 sweep of every priority assignment
    for (int c = 0; c < 256; c++) begin
      int p[4];
      bit taken[4];
      logic [NQ-1:0] got, exp;
      bit ok;
      ok = 1'b1;
      for (int q = 0; q < NQ; q++) begin
        p[q] = (c >> (2 * q)) & 3;
        taken[q] = 1'b0;
        reg_wr(2'd0, 2'(q), 32'(p[q]));
      end
      for (int q = 0; q < NQ; q++) enq(2'(q), 6'(q + 40));
      ready = '1;
      for (int k = 0; k < NQ; k++) begin
        int w;
        w = -1;
        for (int q = 0; q < NQ; q++)
          if (!taken[q] && (w < 0 || p[q] < p[w])) w = q;
        taken[w] = 1'b1;
        exp = '0; exp[w] = 1'b1;
        #1; got = valid;
        if (got !== exp || head(w) !== 6'(w + 40)) ok = 1'b0;
        @(posedge clk); #1;
      end
      ready = '0;
      check($sformatf("R5 order for prio set %0d", c), ok, 1);
    end
    check("R4 all empty", valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule